// File: doc/BRIEF.md
# Timer Channel Sticky Status Register

This block holds the status word for one channel of a capture/compare timer. The channel's counter, compare and capture logic send it single-cycle event pulses: counter overflow, matches on three compare registers (A, B, C), loads of two capture registers (A, B), an external trigger and a safety event. Each pulse sets a sticky flag. All sticky flags clear together when software reads the status word. The same word also shows three live levels: the channel clock-enable state and the current levels of the channel's two I/O lines.

A mode input selects between waveform operation (mode = 1) and capture operation (mode = 0). Capture-load flags and the load-overrun flag can only set in capture mode. Compare-A and compare-B flags can only set in waveform mode. A flag that does not belong to the current mode reads as 0.

The block keeps one pending-unread bit for each capture register. A load sets it and a read strobe of that capture register clears it. A load that arrives while the bit is still set raises the load-overrun flag. A single interrupt output goes high when any visible sticky flag is enabled by a mask input. Software reads the word through a plain read port: a strobe and an address, with the data returned on the next cycle. The word sits at byte offset 0x20 + channel * 0x40.

Top module: `tmr_chan_status`

## Requirements
- R1: After a synchronous reset, `rd_data`, `irq` and every sticky flag are 0. The pending-unread bits are also 0.
- R2: When `rd_en` is high in a cycle and `rd_addr` equals 0x20 + CHAN_IDX*0x40, the status word appears on `rd_data` in the next cycle. A strobe at any other address, or no strobe, gives 0 on `rd_data` and leaves the flags unchanged.
- R3: Sticky flag positions are: bit0 overflow, bit1 load overrun, bit2 compare A, bit3 compare B, bit4 compare C, bit5 capture A loaded, bit6 capture B loaded, bit7 external trigger, bit8 safety event. A one-cycle event pulse sets its flag. The flag stays set until a read at the register's address, and that read clears every sticky flag.
- R4: An event pulse in the same cycle as a status read is not lost. The returned word shows the old state, and the flag is set afterwards.
- R5: The capture-A, capture-B and load-overrun flags set only when `wave_mode` is 0. They read as 0 while `wave_mode` is 1.
- R6: The compare-A and compare-B flags set only when `wave_mode` is 1. They read as 0 while `wave_mode` is 0. Compare-C and overflow set in either mode.
- R7: In capture mode, a load of capture register A or B while that register's pending-unread bit is set raises the load-overrun flag. A capture read strobe clears the pending bit. A load in the same cycle as that register's read strobe leaves the bit set and raises no overrun.
- R8: Bit16 shows `clk_run`, bit17 shows `line_a` and bit18 shows `line_b`. Each value is taken in the read cycle, and a read does not clear these bits.
- R9: `irq` is high in the cycle after the visible sticky flags AND `irq_mask` (same bit order as R3) is nonzero. `irq` is low otherwise.
- R10: Bits 9 to 15 and 19 upward of `rd_data` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Read data, valid the cycle after the strobe |
| ev_ovf | input | 1 | Counter overflow pulse |
| ev_cmp_a | input | 1 | Compare A match pulse |
| ev_cmp_b | input | 1 | Compare B match pulse |
| ev_cmp_c | input | 1 | Compare C match pulse |
| ev_cap_a | input | 1 | Capture register A load pulse |
| ev_cap_b | input | 1 | Capture register B load pulse |
| ev_ext_trig | input | 1 | External trigger pulse |
| ev_safety | input | 1 | Safety event pulse |
| cap_a_rd | input | 1 | Software read strobe of capture register A |
| cap_b_rd | input | 1 | Software read strobe of capture register B |
| wave_mode | input | 1 | 1 = waveform mode, 0 = capture mode |
| clk_run | input | 1 | Channel clock enabled level |
| line_a | input | 1 | Current level of I/O line A |
| line_b | input | 1 | Current level of I/O line B |
| irq_mask | input | 9 | Interrupt enable for each sticky flag |
| irq | output | 1 | Channel interrupt request |

## Verification
A read strobe produces its data one rising edge later, so `rd_data` is due in the cycle after the strobe. An event pulse becomes visible to a read issued in the following cycle, and it shows on `irq` two edges after the pulse. The bench drives all inputs on the falling edge and advances a behavioural model on the rising edge. It compares `rd_data` and `irq` against that model on the next falling edge, so every comparison lands exactly where these latencies put the result. Directed reads at fixed points check the expected constant words for each mode, overrun and same-cycle case.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int N_FLAG   = 9;
  localparam int BIT_OVF  = 0;
  localparam int BIT_OVR  = 1;
  localparam int BIT_CMPA = 2;
  localparam int BIT_CMPB = 3;
  localparam int BIT_CMPC = 4;
  localparam int BIT_LDA  = 5;
  localparam int BIT_LDB  = 6;
  localparam int BIT_TRIG = 7;
  localparam int BIT_SAFE = 8;
  localparam int BIT_CLK  = 16;
  localparam int BIT_LNA  = 17;
  localparam int BIT_LNB  = 18;

  // Flags that are visible in the given mode (1 = waveform, 0 = capture)
  function automatic logic [N_FLAG-1:0] mode_view(input logic wave);
    logic [N_FLAG-1:0] m;
    m = '1;
    if (wave) begin
      m[BIT_LDA] = 1'b0;
      m[BIT_LDB] = 1'b0;
      m[BIT_OVR] = 1'b0;
    end else begin
      m[BIT_CMPA] = 1'b0;
      m[BIT_CMPB] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/tcs_flag_bank.sv
module tcs_flag_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= (q & ~clr_i) | set_i[i];
    end
    assign flags_o[i] = q;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R3
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R4
endmodule

// File: rtl/tcs_load_track.sv
module tcs_load_track #(
  parameter int N_CAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [N_CAP-1:0] ld_i,
  input  logic [N_CAP-1:0] rd_i,
  output logic             ovr_o
);
  logic [N_CAP-1:0] ovr_v;

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    logic pend;
    logic ld_ok;
    assign ld_ok = en_i & ld_i[i];
    always_ff @(posedge clk) begin
      if (rst)        pend <= 1'b0;
      else if (ld_ok) pend <= 1'b1;
      else if (rd_i[i]) pend <= 1'b0;
    end
    assign ovr_v[i] = ld_ok & pend & ~rd_i[i];

    AST_PEND_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
      (en_i && ld_i[i]) |=> pend); // R7
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
      (rd_i[i] && !(en_i && ld_i[i])) |=> !pend); // R7
  end

  assign ovr_o = |ovr_v;
endmodule

// File: rtl/tcs_irq_gen.sv
module tcs_irq_gen #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_i & mask_i);
  end

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(flags_i & mask_i))); // R9
endmodule

// File: rtl/tmr_chan_status.sv
module tmr_chan_status
  import tcs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CHAN_IDX    = 0,
  parameter int BASE_OFS    = 32,
  parameter int CHAN_STRIDE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_ovf,
  input  logic              ev_cmp_a,
  input  logic              ev_cmp_b,
  input  logic              ev_cmp_c,
  input  logic              ev_cap_a,
  input  logic              ev_cap_b,
  input  logic              ev_ext_trig,
  input  logic              ev_safety,
  input  logic              cap_a_rd,
  input  logic              cap_b_rd,
  input  logic              wave_mode,
  input  logic              clk_run,
  input  logic              line_a,
  input  logic              line_b,
  input  logic [N_FLAG-1:0] irq_mask,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] REG_OFS = ADDR_W'(BASE_OFS + CHAN_IDX * CHAN_STRIDE);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << N_FLAG) - 1) | (DATA_W'(1) << BIT_CLK) |
    (DATA_W'(1) << BIT_LNA) | (DATA_W'(1) << BIT_LNB);

  logic              hit;
  logic              cap_mode;
  logic              ovr_evt;
  logic [1:0]        ld_vec;
  logic [1:0]        crd_vec;
  logic [N_FLAG-1:0] set_vec;
  logic [N_FLAG-1:0] flags;
  logic [N_FLAG-1:0] view;
  logic [DATA_W-1:0] word;

  assign hit      = rd_en && (rd_addr == REG_OFS);
  assign cap_mode = ~wave_mode;
  assign ld_vec   = {ev_cap_b, ev_cap_a};
  assign crd_vec  = {cap_b_rd, cap_a_rd};

  tcs_load_track #(.N_CAP(2)) u_track (
    .clk   (clk),
    .rst   (rst),
    .en_i  (cap_mode),
    .ld_i  (ld_vec),
    .rd_i  (crd_vec),
    .ovr_o (ovr_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_OVF]  = ev_ovf;
    set_vec[BIT_OVR]  = ovr_evt;
    set_vec[BIT_CMPA] = ev_cmp_a & wave_mode;
    set_vec[BIT_CMPB] = ev_cmp_b & wave_mode;
    set_vec[BIT_CMPC] = ev_cmp_c;
    set_vec[BIT_LDA]  = ev_cap_a & cap_mode;
    set_vec[BIT_LDB]  = ev_cap_b & cap_mode;
    set_vec[BIT_TRIG] = ev_ext_trig;
    set_vec[BIT_SAFE] = ev_safety;
  end

  tcs_flag_bank #(.N(N_FLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (hit),
    .set_i   (set_vec),
    .flags_o (flags)
  );

  assign view = flags & mode_view(wave_mode);

  always_comb begin
    word                = '0;
    word[N_FLAG-1:0]    = view;
    word[BIT_CLK]       = clk_run;
    word[BIT_LNA]       = line_a;
    word[BIT_LNB]       = line_b;
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (hit) rd_data <= word;
    else          rd_data <= '0;
  end

  tcs_irq_gen #(.N(N_FLAG)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags_i (view),
    .mask_i  (irq_mask),
    .irq_o   (irq)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !irq)); // R1
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rd_data == '0)); // R2
  AST_CAP_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (hit && wave_mode) |=> (!rd_data[BIT_LDA] && !rd_data[BIT_LDB] && !rd_data[BIT_OVR])); // R5
  AST_CMP_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (hit && !wave_mode) |=> (!rd_data[BIT_CMPA] && !rd_data[BIT_CMPB])); // R6
  AST_LIVE_BITS: assert property (@(posedge clk) disable iff (rst)
    hit |=> (rd_data[BIT_CLK] == $past(clk_run) && rd_data[BIT_LNA] == $past(line_a)
             && rd_data[BIT_LNB] == $past(line_b))); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~USED_MASK) == '0); // R10
endmodule

// File: tb/tmr_chan_status_tb.sv
`timescale 1ns/1ps
module tmr_chan_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = 8'h20;
  logic [31:0] rd_data;
  logic        ev_ovf = 0, ev_cmp_a = 0, ev_cmp_b = 0, ev_cmp_c = 0;
  logic        ev_cap_a = 0, ev_cap_b = 0, ev_ext_trig = 0, ev_safety = 0;
  logic        cap_a_rd = 0, cap_b_rd = 0;
  logic        wave_mode = 0, clk_run = 0, line_a = 0, line_b = 0;
  logic [8:0]  irq_mask = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tmr_chan_status dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_ovf(ev_ovf), .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b), .ev_cmp_c(ev_cmp_c),
    .ev_cap_a(ev_cap_a), .ev_cap_b(ev_cap_b), .ev_ext_trig(ev_ext_trig),
    .ev_safety(ev_safety), .cap_a_rd(cap_a_rd), .cap_b_rd(cap_b_rd),
    .wave_mode(wave_mode), .clk_run(clk_run), .line_a(line_a), .line_b(line_b),
    .irq_mask(irq_mask), .irq(irq)
  );

  // Behavioural reference model, advanced on each rising edge
  logic [8:0]  m_flag = '0;
  bit          m_pend_a = 0, m_pend_b = 0;
  logic [31:0] m_rd = '0;
  logic        m_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_flag = '0; m_pend_a = 0; m_pend_b = 0; m_rd = '0; m_irq = 0;
    end else begin
      logic [8:0] vis;
      logic [8:0] nxt;
      bit rd_hit;
      rd_hit = rd_en && (rd_addr == 8'h20);
      vis = m_flag;
      if (wave_mode) begin vis[5] = 0; vis[6] = 0; vis[1] = 0; end
      else begin vis[2] = 0; vis[3] = 0; end
      m_rd = rd_hit ? {13'd0, line_b, line_a, clk_run, 7'd0, vis} : 32'd0;
      m_irq = (vis & irq_mask) != 0;
      nxt = rd_hit ? 9'd0 : m_flag;
      if (ev_ovf) nxt[0] = 1;
      if (ev_cmp_a && wave_mode) nxt[2] = 1;
      if (ev_cmp_b && wave_mode) nxt[3] = 1;
      if (ev_cmp_c) nxt[4] = 1;
      if (ev_ext_trig) nxt[7] = 1;
      if (ev_safety) nxt[8] = 1;
      if (!wave_mode) begin
        if (ev_cap_a) begin nxt[5] = 1; if (m_pend_a && !cap_a_rd) nxt[1] = 1; end
        if (ev_cap_b) begin nxt[6] = 1; if (m_pend_b && !cap_b_rd) nxt[1] = 1; end
      end
      if (!wave_mode && ev_cap_a) m_pend_a = 1; else if (cap_a_rd) m_pend_a = 0;
      if (!wave_mode && ev_cap_b) m_pend_b = 1; else if (cap_b_rd) m_pend_b = 0;
      m_flag = nxt;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (rd_data !== m_rd || irq !== m_irq) begin
        bad++;
        $display("FAIL R3 model compare: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                 rd_data, irq, m_rd, m_irq);
      end
    end
  end

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ev bits: 0 ovf,1 cmp_a,2 cmp_b,3 cmp_c,4 cap_a,5 cap_b,6 trig,7 safety
  task automatic cyc(input logic [7:0] e, input logic [1:0] crd, input bit rd);
    ev_ovf = e[0]; ev_cmp_a = e[1]; ev_cmp_b = e[2]; ev_cmp_c = e[3];
    ev_cap_a = e[4]; ev_cap_b = e[5]; ev_ext_trig = e[6]; ev_safety = e[7];
    cap_a_rd = crd[0]; cap_b_rd = crd[1]; rd_en = rd;
    @(negedge clk);
    {ev_ovf, ev_cmp_a, ev_cmp_b, ev_cmp_c, ev_cap_a, ev_cap_b, ev_ext_trig, ev_safety} = '0;
    cap_a_rd = 0; cap_b_rd = 0; rd_en = 0;
  endtask

  task automatic rd_chk(input logic [31:0] exp, input string tag);
    cyc(8'h00, 2'b00, 1'b1);
    chk32(rd_data, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk32(rd_data, 32'h0, "R1 rd_data after reset");
    chk32({31'd0, irq}, 32'h0, "R1 irq after reset");
    rd_chk(32'h0, "R1 status after reset");

    cyc(8'h01, 2'b00, 0);
    rd_chk(32'h1, "R3 overflow set");
    rd_chk(32'h0, "R3 cleared by read");

    cyc(8'h10, 2'b00, 0);
    rd_chk(32'h20, "R5 capture A load");
    cyc(8'h10, 2'b00, 0);
    rd_chk(32'h22, "R7 second load overrun");
    cyc(8'h00, 2'b01, 0);
    cyc(8'h10, 2'b00, 0);
    rd_chk(32'h20, "R7 read clears pending");

    cyc(8'h20, 2'b00, 0);
    cyc(8'h20, 2'b10, 0);
    rd_chk(32'h40, "R7 load with same-cycle read");
    cyc(8'h20, 2'b00, 0);
    rd_chk(32'h42, "R7 capture B overrun");

    cyc(8'h06, 2'b00, 0);
    rd_chk(32'h0, "R6 compare A/B blocked in capture mode");
    cyc(8'h08, 2'b00, 0);
    rd_chk(32'h10, "R6 compare C in capture mode");

    wave_mode = 1;
    cyc(8'h10, 2'b00, 0);
    cyc(8'h07, 2'b00, 0);
    rd_chk(32'h0D, "R6 compare A/B/overflow in waveform mode");
    cyc(8'h20, 2'b00, 0);
    rd_chk(32'h0, "R5 capture B blocked in waveform mode");

    wave_mode = 0;
    cyc(8'h00, 2'b01, 0);
    cyc(8'h10, 2'b00, 0);
    wave_mode = 1;
    rd_chk(32'h0, "R5 capture flag hidden in waveform mode");
    wave_mode = 0;
    rd_chk(32'h0, "R5 hidden flag cleared by read");

    cyc(8'h40, 2'b00, 1);
    chk32(rd_data, 32'h0, "R4 same-cycle read returns old");
    rd_chk(32'h80, "R4 trigger kept after read");

    cyc(8'h80, 2'b00, 0);
    rd_chk(32'h100, "R10 safety flag, unused bits zero");

    clk_run = 1; line_a = 1;
    rd_chk(32'h30000, "R8 live clock and line A");
    rd_chk(32'h30000, "R8 live bits not cleared");
    line_a = 0; line_b = 1;
    rd_chk(32'h50000, "R8 line B follows level");
    clk_run = 0; line_b = 0;

    rd_addr = 8'h60;
    cyc(8'h01, 2'b00, 0);
    rd_chk(32'h0, "R2 other address returns zero");
    rd_addr = 8'h20;
    rd_chk(32'h1, "R2 other address did not clear");

    irq_mask = 9'h001;
    cyc(8'h01, 2'b00, 0);
    chk32({31'd0, irq}, 32'h0, "R9 irq not yet");
    cyc(8'h00, 2'b00, 0);
    chk32({31'd0, irq}, 32'h1, "R9 irq raised");
    irq_mask = 9'h000;
    cyc(8'h00, 2'b00, 0);
    chk32({31'd0, irq}, 32'h0, "R9 irq masked");
    irq_mask = 9'h001;
    rd_chk(32'h1, "R9 flag still set");
    cyc(8'h00, 2'b00, 0);
    chk32({31'd0, irq}, 32'h0, "R9 irq drops after clear");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule